// File: doc/BRIEF.md
# Compressed instruction expander

This block turns one 16-bit compressed RISC-V instruction into the 32-bit base-ISA word that does the same work. It also flags encodings that are reserved or not supported. It sits between fetch alignment and the main decoder. Each compressed instruction comes in as one beat on a valid/ready stream, and each result goes out as one beat on another valid/ready stream. An out beat carries the 32-bit word and an illegal flag.

The parameter `XLEN` selects 32-bit or 64-bit decoding. This matters because several opcode slots mean different things in the two modes. For example, quadrant 1 funct3 001 is a word add-immediate on 64-bit and a linking jump on 32-bit. Doubleword loads and stores, and the word arithmetic group, exist only on 64-bit.

The parameter `OUT_REG` adds one register stage on the output. With the stage, `in_ready` is high when the stage is empty or when the consumer takes the held beat in the same cycle. Without the stage, the path is combinational and `in_ready` equals `out_ready`. A beat that is offered but not accepted must be held stable by its producer. When `out_valid` is high and `out_ready` is low, the output beat stays stable.

Top module: `rvc_expander`

## Requirements
- R1: Bits [1:0] pick the quadrant and bits [15:13] pick the slot inside it. An input with bits [1:0] = 11 is flagged illegal, and so is the all-zero halfword.
- R2: Quadrant 0 slot 000 becomes ADDI rd', x2, off. Here rd' is x8 plus bits [4:2], and off is the unsigned value {b10..b7, b12..b11, b5, b6} times 4. An offset of zero is illegal.
- R3: Quadrant 0 word and doubleword loads and stores (slots 010, 110, and on 64-bit also 011, 111) use x8 plus bits [9:7] as the base. The data register is x8 plus bits [4:2]. The word offset is {b5, b12..b10, b6} times 4, and the doubleword offset is {b6..b5, b12..b10} times 8.
- R4: Quadrant 1 slot 000 is ADDI rd, rd, simm, and slot 010 is ADDI rd, x0, simm. In both, simm is the signed value {b12, b6..b2}. Slot 001 is ADDIW rd, rd, simm on 64-bit, where rd = 0 is illegal. On 32-bit, slot 001 is JAL x1.
- R5: Quadrant 1 slot 011 with rd = x2 is ADDI x2, x2, off, where off is the signed value {b12, b4..b3, b5, b2, b6} times 16. With any other rd it is LUI rd with upper field sext{b12, b6..b2}. In both forms, b12 = 0 together with bits [6:2] = 0 is illegal.
- R6: Quadrant 1 slot 100 with bits [11:10] = 00, 01 or 10 gives SRLI, SRAI or ANDI on x8 plus bits [9:7]. Quadrant 2 slot 000 gives SLLI on rd. The shift amount is {b12, b6..b2}. On 32-bit, b12 = 1 makes any shift illegal.
- R7: Quadrant 1 slot 100 with bits [11:10] = 11 and b12 = 0 gives SUB, XOR, OR or AND for bits [6:5] = 00, 01, 10, 11. With b12 = 1 it gives SUBW (00) or ADDW (01), on 64-bit only. Every other code in this group is illegal.
- R8: Slot 101 of quadrant 1 is JAL x0 with offset sext{b12, b8, b10..b9, b6, b7, b2, b11, b5..b3} times 2. Slots 110 and 111 are BEQ and BNE, comparing x8 plus bits [9:7] with x0, with offset sext{b12, b6..b5, b2, b11..b10, b4..b3} times 2.
- R9: Quadrant 2 slot 100 is decoded from b12, rs1 and rs2. With b12 = 0 and rs2 = 0 it is JALR x0, 0(rs1), and rs1 = 0 is illegal. With b12 = 0 and rs2 ≠ 0 it is ADDI rd, rs2, 0. With b12 = 1 and both fields zero it is EBREAK. With b12 = 1 and rs2 = 0 it is JALR x1, 0(rs1). With b12 = 1 otherwise it is ADD rd, rd, rs2.
- R10: Quadrant 2 stack-relative accesses use x2 as the base. The word load has offset {b3..b2, b12, b6..b4} times 4. The doubleword load (64-bit only) has offset {b4..b2, b12, b6..b5} times 8. For both loads, rd = 0 is illegal. The word store has offset {b8..b7, b12..b9} times 4, and the doubleword store (64-bit only) has offset {b9..b7, b12..b10} times 8.
- R11: All floating-point slots (quadrant 0 and quadrant 2, slots 001, 101, and 011/111 on 32-bit) are illegal, and so is quadrant 0 slot 100. Whenever the illegal flag is set, the output word is all zeros.
- R12: With `OUT_REG` = 1, `out_valid` is low out of reset. A beat accepted at a clock edge appears at that edge, and it is held while `out_ready` is low. With `OUT_REG` = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A compressed instruction is offered |
| in_ready | output | 1 | The block accepts the offered instruction this cycle |
| in_instr | input | 16 | Compressed instruction |
| out_valid | output | 1 | An expanded result is offered |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | The instruction is reserved or unsupported |

## Verification
Every one of the 65,536 halfwords goes through a 64-bit registered instance and a 32-bit combinational instance at the same time. In each case the expected word is built from arithmetically assembled offsets. The registered result is due at the clock edge that accepts the beat, and the combinational result is already present before that edge. Inputs therefore change on falling edges, and both outputs are sampled 1 ns after the next rising edge, when both must reflect the same input. A back-pressure phase checks that a stalled beat stays unchanged across an edge, that `in_ready` drops, and that the waiting beat goes through on the edge after `out_ready` returns.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMM32  = 7'b0011011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REG32  = 7'b0111011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

  // Operands pulled out of one compressed halfword.
  typedef struct packed {
    logic [4:0]  rd;        // full field [11:7], also rs1
    logic [4:0]  rs2;       // full field [6:2]
    logic [4:0]  rs1c;      // compact [9:7] mapped to x8..x15
    logic [4:0]  rs2c;      // compact [4:2] mapped to x8..x15
    logic [11:0] simm6;     // signed six-bit immediate, extended
    logic [5:0]  shamt;
    logic [11:0] off_spn;   // stack-pointer add, scaled by 4
    logic [11:0] off_w;     // compact word access
    logic [11:0] off_d;     // compact doubleword access
    logic [11:0] off_sp16;  // stack adjust, scaled by 16
    logic [19:0] up_lui;    // upper immediate field
    logic [20:0] off_jmp;   // jump offset
    logic [12:0] off_br;    // branch offset
    logic [11:0] off_lwsp;
    logic [11:0] off_ldsp;
    logic [11:0] off_swsp;
    logic [11:0] off_sdsp;
  } rvc_fields_t;

  function automatic logic [31:0] pack_i(logic [11:0] imm, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] pack_s(logic [11:0] imm, logic [4:0] rs2,
                                         logic [4:0] rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [31:0] pack_b(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [31:0] pack_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [31:0] pack_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

endpackage

// File: rtl/rvc_fields.sv
module rvc_fields
  import rvc_pkg::*;
(
  input  logic [15:0] instr_i,
  output rvc_fields_t fld_o
);
  logic [15:0] c;
  assign c = instr_i;

  always_comb begin
    fld_o.rd       = c[11:7];
    fld_o.rs2      = c[6:2];
    fld_o.rs1c     = {2'b01, c[9:7]};
    fld_o.rs2c     = {2'b01, c[4:2]};
    fld_o.simm6    = {{7{c[12]}}, c[6:2]};
    fld_o.shamt    = {c[12], c[6:2]};
    fld_o.off_spn  = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
    fld_o.off_w    = {5'd0, c[5], c[12:10], c[6], 2'b00};
    fld_o.off_d    = {4'd0, c[6:5], c[12:10], 3'b000};
    fld_o.off_sp16 = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'd0};
    fld_o.up_lui   = {{15{c[12]}}, c[6:2]};
    fld_o.off_jmp  = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
    fld_o.off_br   = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    fld_o.off_lwsp = {4'd0, c[3:2], c[12], c[6:4], 2'b00};
    fld_o.off_ldsp = {3'd0, c[4:2], c[12], c[6:5], 3'b000};
    fld_o.off_swsp = {4'd0, c[8:7], c[12:9], 2'b00};
    fld_o.off_sdsp = {3'd0, c[9:7], c[12:10], 3'b000};
  end
endmodule

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:0]  instr_i,
  input  rvc_fields_t  fld_i,
  output logic [31:0]  word_o,
  output logic         illegal_o
);
  localparam bit IS64 = (XLEN == 64);

  logic [1:0]  quad;
  logic [2:0]  slot;
  logic        b12;
  logic [31:0] raw;
  logic        bad;

  assign quad = instr_i[1:0];
  assign slot = instr_i[15:13];
  assign b12  = instr_i[12];

  always_comb begin
    raw = '0;
    bad = 1'b0;
    case (quad)
      2'b00: begin
        case (slot)
          3'b000: begin
            bad = (fld_i.off_spn == '0);
            raw = pack_i(fld_i.off_spn, 5'd2, 3'b000, fld_i.rs2c, OPC_IMM);
          end
          3'b010: raw = pack_i(fld_i.off_w, fld_i.rs1c, 3'b010, fld_i.rs2c, OPC_LOAD);
          3'b011: begin
            if (IS64) raw = pack_i(fld_i.off_d, fld_i.rs1c, 3'b011, fld_i.rs2c, OPC_LOAD);
            else      bad = 1'b1;
          end
          3'b110: raw = pack_s(fld_i.off_w, fld_i.rs2c, fld_i.rs1c, 3'b010);
          3'b111: begin
            if (IS64) raw = pack_s(fld_i.off_d, fld_i.rs2c, fld_i.rs1c, 3'b011);
            else      bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      2'b01: begin
        case (slot)
          3'b000: raw = pack_i(fld_i.simm6, fld_i.rd, 3'b000, fld_i.rd, OPC_IMM);
          3'b001: begin
            if (IS64) begin
              bad = (fld_i.rd == 5'd0);
              raw = pack_i(fld_i.simm6, fld_i.rd, 3'b000, fld_i.rd, OPC_IMM32);
            end else begin
              raw = pack_j(fld_i.off_jmp, 5'd1);
            end
          end
          3'b010: raw = pack_i(fld_i.simm6, 5'd0, 3'b000, fld_i.rd, OPC_IMM);
          3'b011: begin
            bad = !b12 && (fld_i.rs2 == 5'd0);
            if (fld_i.rd == 5'd2)
              raw = pack_i(fld_i.off_sp16, 5'd2, 3'b000, 5'd2, OPC_IMM);
            else
              raw = {fld_i.up_lui, fld_i.rd, OPC_LUI};
          end
          3'b100: begin
            case (instr_i[11:10])
              2'b00: begin
                bad = !IS64 && b12;
                raw = pack_i({6'b000000, fld_i.shamt}, fld_i.rs1c, 3'b101, fld_i.rs1c, OPC_IMM);
              end
              2'b01: begin
                bad = !IS64 && b12;
                raw = pack_i({6'b010000, fld_i.shamt}, fld_i.rs1c, 3'b101, fld_i.rs1c, OPC_IMM);
              end
              2'b10: raw = pack_i(fld_i.simm6, fld_i.rs1c, 3'b111, fld_i.rs1c, OPC_IMM);
              default: begin
                if (!b12) begin
                  case (instr_i[6:5])
                    2'b00: raw = pack_r(7'b0100000, fld_i.rs2c, fld_i.rs1c, 3'b000, fld_i.rs1c, OPC_REG);
                    2'b01: raw = pack_r(7'b0000000, fld_i.rs2c, fld_i.rs1c, 3'b100, fld_i.rs1c, OPC_REG);
                    2'b10: raw = pack_r(7'b0000000, fld_i.rs2c, fld_i.rs1c, 3'b110, fld_i.rs1c, OPC_REG);
                    default: raw = pack_r(7'b0000000, fld_i.rs2c, fld_i.rs1c, 3'b111, fld_i.rs1c, OPC_REG);
                  endcase
                end else if (IS64 && !instr_i[6]) begin
                  raw = pack_r(instr_i[5] ? 7'b0000000 : 7'b0100000, fld_i.rs2c, fld_i.rs1c,
                               3'b000, fld_i.rs1c, OPC_REG32);
                end else begin
                  bad = 1'b1;
                end
              end
            endcase
          end
          3'b101: raw = pack_j(fld_i.off_jmp, 5'd0);
          3'b110: raw = pack_b(fld_i.off_br, fld_i.rs1c, 3'b000);
          default: raw = pack_b(fld_i.off_br, fld_i.rs1c, 3'b001);
        endcase
      end
      2'b10: begin
        case (slot)
          3'b000: begin
            bad = !IS64 && b12;
            raw = pack_i({6'b000000, fld_i.shamt}, fld_i.rd, 3'b001, fld_i.rd, OPC_IMM);
          end
          3'b010: begin
            bad = (fld_i.rd == 5'd0);
            raw = pack_i(fld_i.off_lwsp, 5'd2, 3'b010, fld_i.rd, OPC_LOAD);
          end
          3'b011: begin
            bad = !IS64 || (fld_i.rd == 5'd0);
            raw = pack_i(fld_i.off_ldsp, 5'd2, 3'b011, fld_i.rd, OPC_LOAD);
          end
          3'b100: begin
            if (!b12) begin
              if (fld_i.rs2 == 5'd0) begin
                bad = (fld_i.rd == 5'd0);
                raw = pack_i(12'd0, fld_i.rd, 3'b000, 5'd0, OPC_JALR);
              end else begin
                raw = pack_i(12'd0, fld_i.rs2, 3'b000, fld_i.rd, OPC_IMM);
              end
            end else if (fld_i.rs2 == 5'd0) begin
              if (fld_i.rd == 5'd0) raw = WORD_EBREAK;
              else                  raw = pack_i(12'd0, fld_i.rd, 3'b000, 5'd1, OPC_JALR);
            end else begin
              raw = pack_r(7'b0000000, fld_i.rs2, fld_i.rd, 3'b000, fld_i.rd, OPC_REG);
            end
          end
          3'b110: raw = pack_s(fld_i.off_swsp, fld_i.rs2, 5'd2, 3'b010);
          3'b111: begin
            bad = !IS64;
            raw = pack_s(fld_i.off_sdsp, fld_i.rs2, 5'd2, 3'b011);
          end
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
  end

  assign illegal_o = bad;
  assign word_o    = bad ? 32'd0 : raw;

  // R1: a full-length encoding and the zero halfword are never expanded
  always_comb begin
    if (instr_i[1:0] == 2'b11 || instr_i == 16'd0) begin
      a_r1_not_compressed: assert (illegal_o);
    end
  end

  // R9: the breakpoint slot yields the fixed system word
  always_comb begin
    if (instr_i == 16'h9002) begin
      a_r9_ebreak_word: assert (word_o == WORD_EBREAK && !illegal_o);
    end
  end

  // R6: on 32-bit, a shift with amount bit 5 set is rejected
  always_comb begin
    if (!IS64 && b12 && ((quad == 2'b01 && slot == 3'b100 && !instr_i[11]) ||
                         (quad == 2'b10 && slot == 3'b000))) begin
      a_r6_rv32_wide_shift: assert (illegal_o);
    end
  end
endmodule

// File: rtl/rvc_out_stage.sv
module rvc_out_stage #(
  parameter int W       = 33,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (OUT_REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) d_q <= in_data;
      end
    end

    assign out_valid = v_q;
    assign out_data  = d_q;

    // R12: a stalled beat keeps its value until taken
    a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R12: an accepted beat is offered right after the accepting edge
    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_instr,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_instr,
  output logic        out_illegal
);
  localparam int WORD_W = 32;
  localparam int BEAT_W = WORD_W + 1;

  rvc_fields_t       fld;
  logic [WORD_W-1:0] dec_word;
  logic              dec_bad;
  logic [BEAT_W-1:0] beat_out;

  rvc_fields u_fields (
    .instr_i (in_instr),
    .fld_o   (fld)
  );

  rvc_decode #(.XLEN(XLEN)) u_decode (
    .instr_i   (in_instr),
    .fld_i     (fld),
    .word_o    (dec_word),
    .illegal_o (dec_bad)
  );

  rvc_out_stage #(.W(BEAT_W), .OUT_REG(OUT_REG)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({dec_bad, dec_word}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (beat_out)
  );

  assign out_illegal = beat_out[WORD_W];
  assign out_instr   = beat_out[WORD_W-1:0];

  // R11: a flagged result never carries a word
  a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_instr == '0);

  // R1: every expanded word is a full-length encoding
  a_r1_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_instr[1:0] == 2'b11);
endmodule

// File: tb/rvc_expander_bench.sv
module rvc_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = '0;
  logic        out_ready = 1'b1;

  logic        rdy64, vld64, ill64;
  logic [31:0] ins64;
  logic        rdy32, vld32, ill32;
  logic [31:0] ins32;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rvc_expander #(.XLEN(64), .OUT_REG(1'b1)) u_rvc_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64), .in_instr(in_instr),
    .out_valid(vld64), .out_ready(out_ready), .out_instr(ins64), .out_illegal(ill64));

  rvc_expander #(.XLEN(32), .OUT_REG(1'b0)) u_rvc_expander_rv32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32), .in_instr(in_instr),
    .out_valid(vld32), .out_ready(out_ready), .out_instr(ins32), .out_illegal(ill32));

  function automatic logic [31:0] u32(logic [4:0] v);
    return {27'd0, v};
  endfunction

  function automatic logic [31:0] mk_i(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                       logic [4:0] rd, logic [6:0] op);
    return {imm[11:0], rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] mk_s(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] mk_b(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] mk_j(logic [31:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction
  function automatic logic [31:0] mk_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  // Reference expansion built from the requirement text
  function automatic void ref_expand(input logic [15:0] c, input bit rv64,
                                     output logic [31:0] w, output bit ill, output string tag);
    logic [4:0]  rd, rs2, p1, p2;
    logic [31:0] s6, off;
    logic [5:0]  sh;
    rd  = c[11:7];
    rs2 = c[6:2];
    p1  = 5'd8 + {2'b00, c[9:7]};
    p2  = 5'd8 + {2'b00, c[4:2]};
    s6  = u32(c[6:2]) - (c[12] ? 32'd32 : 32'd0);
    sh  = {c[12], c[6:2]};
    w = '0; ill = 1'b0; tag = "R11";
    case (c[1:0])
      2'b00: case (c[15:13])
        3'b000: begin
          tag = "R2";
          off = (u32({4'd0, c[6]}) << 2) + (u32({4'd0, c[5]}) << 3)
              + (u32({3'd0, c[12:11]}) << 4) + (u32({1'b0, c[10:7]}) << 6);
          ill = (off == 0); w = mk_i(off, 5'd2, 3'd0, p2, 7'h13);
        end
        3'b010, 3'b110: begin
          tag = "R3";
          off = (u32({4'd0, c[6]}) << 2) + (u32({2'd0, c[12:10]}) << 3)
              + (u32({4'd0, c[5]}) << 6);
          w = c[15] ? mk_s(off, p2, p1, 3'b010) : mk_i(off, p1, 3'b010, p2, 7'h03);
        end
        3'b011, 3'b111: begin
          tag = rv64 ? "R3" : "R11";
          off = (u32({2'd0, c[12:10]}) << 3) + (u32({3'd0, c[6:5]}) << 6);
          ill = !rv64;
          w = c[15] ? mk_s(off, p2, p1, 3'b011) : mk_i(off, p1, 3'b011, p2, 7'h03);
        end
        default: begin tag = (c == 16'd0) ? "R1" : "R11"; ill = 1'b1; end
      endcase
      2'b01: case (c[15:13])
        3'b000: begin tag = "R4"; w = mk_i(s6, rd, 3'd0, rd, 7'h13); end
        3'b010: begin tag = "R4"; w = mk_i(s6, 5'd0, 3'd0, rd, 7'h13); end
        3'b001: begin
          tag = rv64 ? "R4" : "R8";
          if (rv64) begin ill = (rd == 0); w = mk_i(s6, rd, 3'd0, rd, 7'h1b); end
          else begin
            off = (u32({2'd0, c[5:3]}) << 1) + (u32({4'd0, c[11]}) << 4) + (u32({4'd0, c[2]}) << 5)
                + (u32({4'd0, c[7]}) << 6) + (u32({4'd0, c[6]}) << 7) + (u32({3'd0, c[10:9]}) << 8)
                + (u32({4'd0, c[8]}) << 10) - (c[12] ? 32'd2048 : 32'd0);
            w = mk_j(off, 5'd1);
          end
        end
        3'b011: begin
          tag = "R5";
          ill = !c[12] && c[6:2] == 0;
          if (rd == 5'd2) begin
            off = (u32({4'd0, c[6]}) << 4) + (u32({4'd0, c[2]}) << 5) + (u32({4'd0, c[5]}) << 6)
                + (u32({3'd0, c[4:3]}) << 7) - (c[12] ? 32'd512 : 32'd0);
            w = mk_i(off, 5'd2, 3'd0, 5'd2, 7'h13);
          end else w = {s6[19:0], rd, 7'h37};
        end
        3'b100: case (c[11:10])
          2'b00: begin tag = "R6"; ill = !rv64 && c[12]; w = mk_i({26'd0, sh}, p1, 3'b101, p1, 7'h13); end
          2'b01: begin tag = "R6"; ill = !rv64 && c[12]; w = mk_i({20'd0, 6'h10, sh}, p1, 3'b101, p1, 7'h13); end
          2'b10: begin tag = "R6"; w = mk_i(s6, p1, 3'b111, p1, 7'h13); end
          default: begin
            tag = "R7";
            if (!c[12]) case (c[6:5])
              2'b00: w = mk_r(7'h20, p2, p1, 3'b000, p1, 7'h33);
              2'b01: w = mk_r(7'h00, p2, p1, 3'b100, p1, 7'h33);
              2'b10: w = mk_r(7'h00, p2, p1, 3'b110, p1, 7'h33);
              default: w = mk_r(7'h00, p2, p1, 3'b111, p1, 7'h33);
            endcase
            else if (rv64 && c[6:5] == 2'b00) w = mk_r(7'h20, p2, p1, 3'b000, p1, 7'h3b);
            else if (rv64 && c[6:5] == 2'b01) w = mk_r(7'h00, p2, p1, 3'b000, p1, 7'h3b);
            else ill = 1'b1;
          end
        endcase
        3'b101: begin
          tag = "R8";
          off = (u32({2'd0, c[5:3]}) << 1) + (u32({4'd0, c[11]}) << 4) + (u32({4'd0, c[2]}) << 5)
              + (u32({4'd0, c[7]}) << 6) + (u32({4'd0, c[6]}) << 7) + (u32({3'd0, c[10:9]}) << 8)
              + (u32({4'd0, c[8]}) << 10) - (c[12] ? 32'd2048 : 32'd0);
          w = mk_j(off, 5'd0);
        end
        default: begin
          tag = "R8";
          off = (u32({3'd0, c[4:3]}) << 1) + (u32({3'd0, c[11:10]}) << 3) + (u32({4'd0, c[2]}) << 5)
              + (u32({3'd0, c[6:5]}) << 6) - (c[12] ? 32'd256 : 32'd0);
          w = mk_b(off, p1, c[13] ? 3'b001 : 3'b000);
        end
      endcase
      2'b10: case (c[15:13])
        3'b000: begin tag = "R6"; ill = !rv64 && c[12]; w = mk_i({26'd0, sh}, rd, 3'b001, rd, 7'h13); end
        3'b010: begin
          tag = "R10";
          off = (u32({2'd0, c[6:4]}) << 2) + (u32({4'd0, c[12]}) << 5) + (u32({3'd0, c[3:2]}) << 6);
          ill = (rd == 0); w = mk_i(off, 5'd2, 3'b010, rd, 7'h03);
        end
        3'b011: begin
          tag = rv64 ? "R10" : "R11";
          off = (u32({3'd0, c[6:5]}) << 3) + (u32({4'd0, c[12]}) << 5) + (u32({2'd0, c[4:2]}) << 6);
          ill = !rv64 || rd == 0; w = mk_i(off, 5'd2, 3'b011, rd, 7'h03);
        end
        3'b100: begin
          tag = "R9";
          if (!c[12] && rs2 == 0) begin ill = (rd == 0); w = mk_i(0, rd, 3'd0, 5'd0, 7'h67); end
          else if (!c[12]) w = mk_i(0, rs2, 3'd0, rd, 7'h13);
          else if (rs2 == 0 && rd == 0) w = 32'h0010_0073;
          else if (rs2 == 0) w = mk_i(0, rd, 3'd0, 5'd1, 7'h67);
          else w = mk_r(7'h00, rs2, rd, 3'd0, rd, 7'h33);
        end
        3'b110: begin
          tag = "R10";
          off = (u32({1'b0, c[12:9]}) << 2) + (u32({3'd0, c[8:7]}) << 6);
          w = mk_s(off, rs2, 5'd2, 3'b010);
        end
        3'b111: begin
          tag = rv64 ? "R10" : "R11";
          off = (u32({2'd0, c[12:10]}) << 3) + (u32({2'd0, c[9:7]}) << 6);
          ill = !rv64; w = mk_s(off, rs2, 5'd2, 3'b011);
        end
        default: begin tag = "R11"; ill = 1'b1; end
      endcase
      default: begin tag = "R1"; ill = 1'b1; end
    endcase
    if (ill) w = '0;
  endfunction

  task automatic check(string tag, string what, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w64, w32, wa, wb;
    bit          i64, i32, ia, ib;
    string       t64, t32, ta, tb;

    // R12: reset state of the registered instance
    repeat (3) @(posedge clk);
    #1;
    check("R12", "reset out_valid/in_ready", {32'd0, vld64, rdy64}, {32'd0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive sweep on both configurations
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      in_instr = k[15:0];
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      ref_expand(in_instr, 1'b1, w64, i64, t64);
      ref_expand(in_instr, 1'b0, w32, i32, t32);
      check(t64, $sformatf("rv64 %h", in_instr), {vld64, i64 ? ill64 : ill64, ins64},
            {1'b1, i64, w64});
      check(t32, $sformatf("rv32 %h", in_instr), {vld32, ill32, ins32}, {1'b1, i32, w32});
    end

    // R12: back-pressure on the registered instance
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    ref_expand(16'h4501, 1'b1, wa, ia, ta);
    ref_expand(16'h852e, 1'b1, wb, ib, tb);
    in_instr = 16'h4501; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    check("R12", "captured beat", {vld64, ill64, ins64}, {1'b1, ia, wa});
    check("R12", "ready low when full", {33'd0, rdy64}, {33'd0, 1'b0});
    check("R12", "comb ready follows out_ready", {33'd0, rdy32}, {33'd0, 1'b0});
    @(negedge clk);
    in_instr = 16'h852e;
    @(posedge clk); #1;
    check("R12", "held while stalled", {vld64, ill64, ins64}, {1'b1, ia, wa});
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    check("R12", "next beat after release", {vld64, ill64, ins64}, {1'b1, ib, wb});
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R12", "empty after drain", {33'd0, vld64}, {33'd0, 1'b0});
    finish_run();
  end
endmodule